// File: doc/BRIEF.md
# Interrupt controller register bank

This block is the memory-mapped state store of a nested interrupt controller with 114 interrupt lines. Software reaches it over a simple single-cycle 32-bit bus. The bus carries a request, a write flag, a 12-bit byte address, write data, four byte strobes and a privilege flag. The block answers with registered read data and a one-cycle error flag. For every line it holds an enable bit, a pending bit and a priority level. It also shows the active state that the processor core reports. The enable, pending and priority values are driven out as flat vectors for an arbiter that lives outside the block.

Enable and pending each have two address windows of four 32-bit banks. A 1 written to the set window sets a bit and a 1 written to the clear window clears it. Line n sits in bank n/32 at bit n%32. Priority words hold four lines each, one byte per line. A trigger register pends one line when software writes that line's number to it. Pending never depends on enable. Every access is checked for privilege and alignment. The only access allowed from unprivileged code is a write to the trigger register, and only while the permit input is high.

Top module: `irq_regbank`

## Requirements
- R1: After reset every enable, pending and priority bit is zero, and err_o and rdata_o are zero.
- R2: A write to byte offset 0x100+4b sets, and a write to 0x180+4b clears, every enable bit of bank b (lines 32b..32b+31) whose data bit is 1 and whose byte strobe is set. Data bits that are 0 leave their enable bits unchanged. A read of either window returns the bank's current enable bits. Bits for lines 114 and above read 0.
- R3: Pending has the same scheme at 0x200+4b (set) and 0x280+4b (clear). Pending bits set and clear whatever the enable bits hold.
- R4: A read at 0x300+4b returns active_i for lines 32b..32b+31, with 0 for lines 114 and above. A write there changes no state and gives no error.
- R5: Priority word w sits at 0x400+4w (w 0..28). Byte k of word w belongs to line 4w+k. Only data bits [7:5] of a byte are stored, and only when that byte's strobe is set. A read returns the stored level in bits [7:5] of each byte, with the other bits 0. Bytes for lines 114 and above read 0. prio_o[3n+2:3n] carries line n's level.
- R6: A write to 0xF00 with strobe 0 set pends line wdata_i[7:0] if that value is below 114. Values of 114 and above change nothing. A read of 0xF00 returns 0.
- R7: Any access with priv_i=0 gives err_o=1, changes no state and returns rdata_o=0. The one exception is a write to 0xF00 while user_pend_en_i=1: that write acts as in R6 and gives no error.
- R8: Any access with addr_i[1:0] not zero gives err_o=1, changes no state and returns rdata_o=0.
- R9: A privileged aligned access to an offset not listed above gives no error, reads 0 and changes no state.
- R10: rdata_o and err_o belong to the request sampled at the previous rising edge and are 0 after a cycle with no request. State written at an edge is visible on enable_o, pending_o and prio_o right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request this cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes |
| priv_i | input | 1 | Access is privileged |
| user_pend_en_i | input | 1 | Permit unprivileged trigger writes |
| active_i | input | 114 | Per-line active state from the core |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered bus error, one cycle per faulting access |
| enable_o | output | 114 | Per-line enable |
| pending_o | output | 114 | Per-line pending |
| prio_o | output | 342 | Per-line priority, 3 bits each |

## Verification
Every bank of the enable and pending windows is written with all-ones data, with alternating-bit data and with partial byte strobes. This separates strobe masking, set-versus-clear direction and the handling of the unused lines in the last bank. Each priority word gets a data value derived from its index, and one word is then rewritten with a single strobe. This exposes wrong byte-to-line mapping and storage of low bits. The trigger register is swept with every value from 0 to 127, so the in-range lines and the rejected values above 113 are both covered. Unprivileged, misaligned and reserved accesses are each replayed against a known state, and every vector output is then compared.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

  localparam int unsigned SETEN_OFS   = 32'h100;
  localparam int unsigned CLREN_OFS   = 32'h180;
  localparam int unsigned SETPEND_OFS = 32'h200;
  localparam int unsigned CLRPEND_OFS = 32'h280;
  localparam int unsigned ACTIVE_OFS  = 32'h300;
  localparam int unsigned PRIO_OFS    = 32'h400;
  localparam int unsigned TRIG_OFS    = 32'hF00;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_SETEN,
    RG_CLREN,
    RG_SETPEND,
    RG_CLRPEND,
    RG_ACTIVE,
    RG_PRIO,
    RG_TRIG
  } region_e;

  function automatic logic [31:0] be_mask(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned NUM_BANKS      = 4,
  parameter int unsigned NUM_PRIO_WORDS = 29
) (
  input  logic [ADDR_W-3:0] waddr_i,
  output region_e           region_o,
  output logic [5:0]        idx_o
);

  function automatic logic in_win(int unsigned a, int unsigned base, int unsigned n);
    return (a >= base) && (a < base + 4*n);
  endfunction

  always_comb begin
    int unsigned a;
    a = 32'({waddr_i, 2'b00});
    region_o = RG_NONE;
    idx_o    = '0;
    if (in_win(a, SETEN_OFS, NUM_BANKS)) begin
      region_o = RG_SETEN;   idx_o = 6'((a - SETEN_OFS) >> 2);
    end else if (in_win(a, CLREN_OFS, NUM_BANKS)) begin
      region_o = RG_CLREN;   idx_o = 6'((a - CLREN_OFS) >> 2);
    end else if (in_win(a, SETPEND_OFS, NUM_BANKS)) begin
      region_o = RG_SETPEND; idx_o = 6'((a - SETPEND_OFS) >> 2);
    end else if (in_win(a, CLRPEND_OFS, NUM_BANKS)) begin
      region_o = RG_CLRPEND; idx_o = 6'((a - CLRPEND_OFS) >> 2);
    end else if (in_win(a, ACTIVE_OFS, NUM_BANKS)) begin
      region_o = RG_ACTIVE;  idx_o = 6'((a - ACTIVE_OFS) >> 2);
    end else if (in_win(a, PRIO_OFS, NUM_PRIO_WORDS)) begin
      region_o = RG_PRIO;    idx_o = 6'((a - PRIO_OFS) >> 2);
    end else if (a == TRIG_OFS) begin
      region_o = RG_TRIG;
    end
  end

endmodule

// File: rtl/irq_bit_bank.sv
module irq_bit_bank #(
  parameter int unsigned NUM_LINES = 114
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_we_i,
  input  logic                 clr_we_i,
  input  logic [5:0]           bank_i,
  input  logic [31:0]          wmask_i,
  input  logic [NUM_LINES-1:0] line_set_i,
  output logic [NUM_LINES-1:0] state_o
);

  logic [NUM_LINES-1:0] state_q, hit;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++)
      hit[l] = (32'(bank_i) == 32'(l / 32)) && wmask_i[l % 32];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= '0;
    else if (set_we_i) state_q <= state_q | hit | line_set_i;
    else if (clr_we_i) state_q <= (state_q & ~hit) | line_set_i;
    else               state_q <= state_q | line_set_i;
  end

  assign state_o = state_q;

  AST_SET_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((state_q & $past(state_q)) == $past(state_q))); // R2
  AST_CLR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && line_set_i == '0) |=> ((state_q | $past(state_q)) == $past(state_q))); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i && line_set_i == '0) |=> $stable(state_q)); // R8

endmodule

// File: rtl/irq_prio_file.sv
module irq_prio_file #(
  parameter int unsigned NUM_LINES = 114,
  parameter int unsigned PRIO_BITS = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [5:0]                     word_i,
  input  logic [3:0]                     be_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  output logic [NUM_LINES*PRIO_BITS-1:0] prio_o
);

  logic [NUM_LINES*PRIO_BITS-1:0] prio_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam int unsigned BYTE = l % 4;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_q[l*PRIO_BITS +: PRIO_BITS] <= '0;
      else if (we_i && 32'(word_i) == 32'(l / 4) && be_i[BYTE])
        prio_q[l*PRIO_BITS +: PRIO_BITS] <= PRIO_BITS'(wdata_i[8*BYTE +: 8] >> (8 - PRIO_BITS));
    end
  end

  // implemented bits sit at the top of each byte
  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (32'(word_i) == 32'(l / 4))
        rdata_o[8*(l % 4) + 8 - PRIO_BITS +: PRIO_BITS] = prio_q[l*PRIO_BITS +: PRIO_BITS];
  end

  assign prio_o = prio_q;

  AST_PRIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(prio_q)); // R5

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 114,
  parameter int unsigned PRIO_BITS = 3,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  input  logic [3:0]                     be_i,
  input  logic                           priv_i,
  input  logic                           user_pend_en_i,
  input  logic [NUM_LINES-1:0]           active_i,
  output logic [31:0]                    rdata_o,
  output logic                           err_o,
  output logic [NUM_LINES-1:0]           enable_o,
  output logic [NUM_LINES-1:0]           pending_o,
  output logic [NUM_LINES*PRIO_BITS-1:0] prio_o
);

  localparam int unsigned NUM_BANKS      = (NUM_LINES + 31) / 32;
  localparam int unsigned NUM_PRIO_WORDS = (NUM_LINES + 3) / 4;

  region_e              region;
  logic [5:0]           idx;
  logic                 aligned, unpriv_ok, allowed, wr, rd;
  logic [31:0]          wmask, prio_rd, rd_mux, rdata_q;
  logic                 err_q;
  logic [7:0]           trig_line;
  logic                 trig_ok;
  logic [NUM_LINES-1:0] trig_set;

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .NUM_PRIO_WORDS(NUM_PRIO_WORDS)
  ) u_dec (
    .waddr_i (addr_i[ADDR_W-1:2]),
    .region_o(region),
    .idx_o   (idx)
  );

  assign aligned   = (addr_i[1:0] == 2'b00);
  assign unpriv_ok = we_i && (region == RG_TRIG) && user_pend_en_i;
  assign allowed   = req_i && aligned && (priv_i || unpriv_ok);
  assign wr        = allowed && we_i;
  assign rd        = allowed && !we_i;
  assign wmask     = wdata_i & be_mask(be_i);

  assign trig_line = wdata_i[7:0];
  assign trig_ok   = wr && (region == RG_TRIG) && be_i[0] && (32'(trig_line) < NUM_LINES);

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) trig_set[l] = trig_ok && (32'(trig_line) == l);
  end

  irq_bit_bank #(.NUM_LINES(NUM_LINES)) u_enable (
    .clk_i, .rst_ni,
    .set_we_i  (wr && region == RG_SETEN),
    .clr_we_i  (wr && region == RG_CLREN),
    .bank_i    (idx),
    .wmask_i   (wmask),
    .line_set_i('0),
    .state_o   (enable_o)
  );

  irq_bit_bank #(.NUM_LINES(NUM_LINES)) u_pending (
    .clk_i, .rst_ni,
    .set_we_i  (wr && region == RG_SETPEND),
    .clr_we_i  (wr && region == RG_CLRPEND),
    .bank_i    (idx),
    .wmask_i   (wmask),
    .line_set_i(trig_set),
    .state_o   (pending_o)
  );

  irq_prio_file #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_prio (
    .clk_i, .rst_ni,
    .we_i   (wr && region == RG_PRIO),
    .word_i (idx),
    .be_i   (be_i),
    .wdata_i(wdata_i),
    .rdata_o(prio_rd),
    .prio_o (prio_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (32'(idx) == 32'(l / 32)) begin
        unique case (region)
          RG_SETEN, RG_CLREN:     rd_mux[l % 32] = enable_o[l];
          RG_SETPEND, RG_CLRPEND: rd_mux[l % 32] = pending_o[l];
          RG_ACTIVE:              rd_mux[l % 32] = active_i[l];
          default: ;
        endcase
      end
    end
    if (region == RG_PRIO) rd_mux = prio_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd ? rd_mux : '0;
      err_q   <= req_i && !allowed;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  AST_UNPRIV_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && !(we_i && region == RG_TRIG && user_pend_en_i)) |=> err_o); // R7
  AST_TRIG_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && aligned && region == RG_TRIG && user_pend_en_i) |=> !err_o); // R7
  AST_MISALIGN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !aligned) |=> (err_o && rdata_o == '0)); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !allowed) |=> ($stable(enable_o) && $stable(pending_o) && $stable(prio_o))); // R7
  AST_IDLE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!err_o && rdata_o == '0)); // R10

endmodule

// File: tb/irq_regbank_tb_top.sv
module irq_regbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 114;
  localparam int PB = 3;

  logic            clk_i = 1'b0, rst_ni = 1'b0;
  logic            req_i = 0, we_i = 0, priv_i = 0, user_pend_en_i = 0;
  logic [11:0]     addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [3:0]      be_i = '0;
  logic [NL-1:0]   active_i = '0;
  logic [31:0]     rdata_o;
  logic            err_o;
  logic [NL-1:0]   enable_o, pending_o;
  logic [NL*PB-1:0] prio_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [127:0]    en_m, pend_m;
  logic [NL*PB-1:0] pr_m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_regbank dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i, .priv_i,
    .user_pend_en_i, .active_i, .rdata_o, .err_o, .enable_o, .pending_o, .prio_o
  );

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic pv,
                     output logic [31:0] rd, output logic er);
    @(negedge clk_i);
    req_i = 1; we_i = w; addr_i = a; wdata_i = d; be_i = be; priv_i = pv;
    @(negedge clk_i);
    rd = rdata_o; er = err_o;
    req_i = 0; we_i = 0; priv_i = 0;
  endtask

  function automatic logic [31:0] valid_mask(int b);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (32*b + i) < NL;
    return m;
  endfunction

  function automatic logic [31:0] bmask(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] prio_word(int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < NL) r[8*k+5 +: 3] = pr_m[(4*w+k)*PB +: PB];
    return r;
  endfunction

  task automatic chk_state(string tag);
    chk({tag, " enable_o"},  enable_o,  en_m[NL-1:0]);
    chk({tag, " pending_o"}, pending_o, pend_m[NL-1:0]);
    chk({tag, " prio_o"},    prio_o,    pr_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, p;
    logic er;
    en_m = '0; pend_m = '0; pr_m = '0;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_state("R1");
    chk("R1 err_o", err_o, 0);
    chk("R1 rdata_o", rdata_o, 0);

    // R2 enable set/clear per bank
    for (int b = 0; b < 4; b++) begin
      for (int pi = 0; pi < 2; pi++) begin
        p = (pi == 0) ? 32'hA5A5_5A5A ^ (32'h0101_0101 * b) : 32'hFFFF_FFFF;
        acc(1, 12'(32'h100 + 4*b), p, 4'hF, 1, rd, er);
        en_m[32*b +: 32] |= p & valid_mask(b);
        chk("R2 set err", er, 0);
        acc(0, 12'(32'h100 + 4*b), 0, 4'hF, 1, rd, er);
        chk("R2 set-window read", rd, en_m[32*b +: 32]);
        acc(0, 12'(32'h180 + 4*b), 0, 4'hF, 1, rd, er);
        chk("R2 clr-window read", rd, en_m[32*b +: 32]);
      end
      p = 32'h0F0F_F0F3;
      acc(1, 12'(32'h180 + 4*b), p, 4'b0101, 1, rd, er);
      en_m[32*b +: 32] &= ~(p & bmask(4'b0101));
      acc(0, 12'(32'h180 + 4*b), 0, 4'hF, 1, rd, er);
      chk("R2 strobed clear", rd, en_m[32*b +: 32]);
    end
    chk_state("R2");

    // R3 pending independent of enable: clear all enables first
    for (int b = 0; b < 4; b++) acc(1, 12'(32'h180 + 4*b), '1, 4'hF, 1, rd, er);
    en_m = '0;
    for (int b = 0; b < 4; b++) begin
      p = 32'h3C96_C369 + 32'(b * 32'h1111);
      acc(1, 12'(32'h200 + 4*b), p, 4'b1011, 1, rd, er);
      pend_m[32*b +: 32] |= p & bmask(4'b1011) & valid_mask(b);
      acc(0, 12'(32'h280 + 4*b), 0, 4'hF, 1, rd, er);
      chk("R3 set then read", rd, pend_m[32*b +: 32]);
      acc(1, 12'(32'h280 + 4*b), 32'h0000_FFFF, 4'hF, 1, rd, er);
      pend_m[32*b +: 32] &= 32'hFFFF_0000;
      acc(0, 12'(32'h200 + 4*b), 0, 4'hF, 1, rd, er);
      chk("R3 clear then read", rd, pend_m[32*b +: 32]);
    end
    chk_state("R3");

    // R4 active read-only
    active_i = {18'h2B5A3, 32'hDEAD_BEEF, 32'h1234_5678, 32'h8001_7FFE};
    for (int b = 0; b < 4; b++) begin
      acc(0, 12'(32'h300 + 4*b), 0, 4'hF, 1, rd, er);
      chk("R4 active read", rd, 32'({14'h0, active_i} >> (32*b)));
      acc(1, 12'(32'h300 + 4*b), '1, 4'hF, 1, rd, er);
      chk("R4 write err", er, 0);
    end
    chk_state("R4");

    // R5 priority words
    for (int w = 0; w < 29; w++) begin
      p = 32'(w) * 32'h2F6B_1D47 + 32'h9E37_79B9;
      acc(1, 12'(32'h400 + 4*w), p, 4'hF, 1, rd, er);
      for (int k = 0; k < 4; k++)
        if (4*w + k < NL) pr_m[(4*w+k)*PB +: PB] = p[8*k+5 +: 3];
    end
    for (int w = 0; w < 29; w++) begin
      acc(0, 12'(32'h400 + 4*w), 0, 4'hF, 1, rd, er);
      chk("R5 prio read", rd, prio_word(w));
    end
    acc(1, 12'h40C, 32'hFFFF_FFFF ^ 32'h0000_E000, 4'b0010, 1, rd, er);
    pr_m[13*PB +: PB] = 3'b000;
    acc(0, 12'h40C, 0, 4'hF, 1, rd, er);
    chk("R5 single strobe", rd, prio_word(3));
    chk_state("R5");

    // R6 trigger sweep
    for (int b = 0; b < 4; b++) acc(1, 12'(32'h280 + 4*b), '1, 4'hF, 1, rd, er);
    pend_m = '0;
    for (int n = 0; n < 128; n++) begin
      acc(1, 12'hF00, 32'(n) | 32'hFFFF_0000, 4'b0001, 1, rd, er);
      if (n < NL) pend_m[n] = 1'b1;
      chk("R6 trigger pending_o", pending_o, pend_m[NL-1:0]);
    end
    for (int b = 0; b < 4; b++) acc(1, 12'(32'h280 + 4*b), '1, 4'hF, 1, rd, er);
    pend_m = '0;
    acc(0, 12'hF00, 0, 4'hF, 1, rd, er);
    chk("R6 trigger read", rd, 0);
    chk("R6 trigger read err", er, 0);

    // R7 privilege
    acc(1, 12'h100, 32'h0000_00FF, 4'hF, 1, rd, er);
    en_m[7:0] = 8'hFF;
    acc(0, 12'h100, 0, 4'hF, 0, rd, er);
    chk("R7 unpriv read err", er, 1);
    chk("R7 unpriv read data", rd, 0);
    acc(1, 12'h184, '1, 4'hF, 0, rd, er);
    chk("R7 unpriv write err", er, 1);
    acc(1, 12'h180, '1, 4'hF, 0, rd, er);
    acc(1, 12'h400, '1, 4'hF, 0, rd, er);
    acc(1, 12'hF00, 32'd5, 4'h1, 0, rd, er);
    chk("R7 unpriv trigger blocked err", er, 1);
    chk_state("R7 blocked");
    user_pend_en_i = 1;
    acc(1, 12'hF00, 32'd77, 4'h1, 0, rd, er);
    pend_m[77] = 1'b1;
    chk("R7 permitted trigger err", er, 0);
    acc(0, 12'hF00, 0, 4'hF, 0, rd, er);
    chk("R7 unpriv trigger read err", er, 1);
    acc(1, 12'h200, '1, 4'hF, 0, rd, er);
    chk("R7 unpriv setpend err", er, 1);
    user_pend_en_i = 0;
    chk_state("R7 permitted");

    // R8 misaligned
    acc(1, 12'h101, '1, 4'hF, 1, rd, er);
    chk("R8 misaligned set err", er, 1);
    acc(1, 12'h282, '1, 4'hF, 1, rd, er);
    acc(1, 12'h403, '1, 4'hF, 1, rd, er);
    acc(1, 12'hF01, 32'd9, 4'h1, 1, rd, er);
    chk("R8 misaligned trigger err", er, 1);
    acc(0, 12'h102, 0, 4'hF, 1, rd, er);
    chk("R8 misaligned read data", rd, 0);
    chk_state("R8");

    // R9 reserved offsets
    for (int i = 0; i < 5; i++) begin
      logic [11:0] ra;
      ra = (i == 0) ? 12'h110 : (i == 1) ? 12'h474 : (i == 2) ? 12'h500 :
           (i == 3) ? 12'hF04 : 12'h000;
      acc(1, ra, '1, 4'hF, 1, rd, er);
      chk("R9 reserved write err", er, 0);
      acc(0, ra, 0, 4'hF, 1, rd, er);
      chk("R9 reserved read", rd, 0);
    end
    chk_state("R9");

    // R10 response timing
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 12'h108; wdata_i = 32'h0000_0030; be_i = 4'hF; priv_i = 1;
    @(negedge clk_i);
    en_m[69:68] = 2'b11;
    chk("R10 enable after one edge", enable_o, en_m[NL-1:0]);
    we_i = 0; addr_i = 12'h108;
    @(negedge clk_i);
    chk("R10 read data next cycle", rdata_o, en_m[95:64]);
    req_i = 0;
    @(negedge clk_i);
    chk("R10 idle rdata", rdata_o, 0);
    addr_i = 12'h101; req_i = 1;
    @(negedge clk_i);
    req_i = 0;
    chk("R10 err pulse", err_o, 1);
    @(negedge clk_i);
    chk("R10 err drops", err_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule